// File: doc/BRIEF.md
# Hex Record Line Decoder

This block sits behind a serial receiver and turns a stream of ASCII characters into checked hex-format records. A record opens with a colon, carries pairs of hex digits for a byte count, a 16-bit load address, a record type, the data bytes and a checksum, and closes with a carriage return or line feed. The block decodes each digit pair into a byte, keeps the data bytes in a local buffer and adds every decoded byte into a running 8-bit sum.

Nothing is released until the whole record has arrived and its sum has been checked. A good record raises a valid flag that presents the type, address, length and a read port into the data buffer, and a one-character acknowledge ('.') is sent towards a serial transmitter. A bad record is thrown away and a single 'X' is sent instead. The consumer reads the buffer and pulses an acknowledge to free the block for the next record.

Top module: `ihex_rx`

## Requirements
- R1: After reset `tx_valid` and `rec_valid` are 0.
- R2: Characters received while no record is open, other than ':' (0x3A), produce no reply and no record.
- R3: A record whose 8-bit sum of all decoded bytes, count through checksum, is zero and whose checksum pair is followed by CR (0x0D) or LF (0x0A) raises `rec_valid` one cycle after that line-end character is accepted, with `rec_len` = count, `rec_addr` = the address (first pair is the high byte), `rec_type` = type, and data byte i readable at `rd_data` when `rd_idx` = i; in the same cycle `tx_valid` pulses for one cycle with `tx_data` = 0x2E ('.').
- R4: A record whose sum is not zero produces a one-cycle `tx_valid` pulse with `tx_data` = 0x58 ('X') one cycle after the line end, and `rec_valid` stays 0.
- R5: A count above 32 (0x20) is rejected with an 'X' pulse one cycle after the second count digit; the block then waits for ':' again.
- R6: Hex digits 0-9, A-F and a-f are all accepted, upper and lower case giving the same value.
- R7: Any non-hex character where a digit is expected aborts the record with an 'X' pulse one cycle later; the next ':' starts a fresh record normally.
- R8: A count of zero with address 0000 is accepted; the type byte is passed through unchanged for type 0x00, end-of-file type 0x01 and any other type.
- R9: While `rec_valid` is 1 and `rec_ack` is 0, the type, address, length and buffer contents stay unchanged and received characters are ignored (no reply); `rec_ack` clears `rec_valid` on the next cycle.
- R10: A record of exactly 32 data bytes is accepted with all 32 bytes readable.
- R11: A character other than CR or LF directly after the checksum pair aborts the record with an 'X' pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received ASCII character |
| tx_valid | output | 1 | One-cycle pulse: reply character present |
| tx_data | output | 8 | Reply character, '.' or 'X' |
| rec_valid | output | 1 | A checked record is held for the consumer |
| rec_type | output | 8 | Record type byte |
| rec_addr | output | 16 | Record load address |
| rec_len | output | 6 | Number of data bytes (0 to 32) |
| rd_idx | input | 5 | Buffer read index |
| rd_data | output | 8 | Data byte at `rd_idx` |
| rec_ack | input | 1 | Consumer has taken the record |

## Verification
The bench goes after the length limits: a 32-byte record that a design with an off-by-one index would truncate or misplace, a count of 33 that a missing limit check would swallow and then mis-frame, and an empty end-of-file record that a design treating the checksum as data would reject. It sends a record with a checksum off by one, which a design skipping the sum would acknowledge, and lower-case digits, which a decoder handling upper case only would abort. It also sends a second record while the first is still held, where a design that keeps listening would overwrite the buffer or reply early, and stray characters where a design that frames loosely would reply with 'X' outside any record.

// File: rtl/ihex_rx.sv
module ihex_rx #(
  parameter int          MAX_LEN  = 32,
  parameter logic [7:0]  ACK_CHAR = 8'h2E,
  parameter logic [7:0]  NAK_CHAR = 8'h58
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_data,
  output logic                        tx_valid,
  output logic [7:0]                  tx_data,
  output logic                        rec_valid,
  output logic [7:0]                  rec_type,
  output logic [15:0]                 rec_addr,
  output logic [$clog2(MAX_LEN+1)-1:0] rec_len,
  input  logic [$clog2(MAX_LEN)-1:0]  rd_idx,
  output logic [7:0]                  rd_data,
  input  logic                        rec_ack
);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int AW = $clog2(MAX_LEN);
  localparam int BW = $clog2(MAX_LEN + 6);

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_EOL} st_t;

  st_t           st;
  logic [BW-1:0] idx;
  logic [7:0]    sum;
  logic [3:0]    hi_q;
  logic [LW-1:0] len_q;
  logic [7:0]    buf_q [MAX_LEN];
  logic          hx_ok;
  logic [3:0]    hx_val;

  always_comb begin
    hx_ok  = 1'b1;
    hx_val = 4'd0;
    if (rx_data >= 8'h30 && rx_data <= 8'h39)      hx_val = 4'(rx_data - 8'h30);
    else if (rx_data >= 8'h41 && rx_data <= 8'h46) hx_val = 4'(rx_data - 8'h37);
    else if (rx_data >= 8'h61 && rx_data <= 8'h66) hx_val = 4'(rx_data - 8'h57);
    else                                           hx_ok  = 1'b0;
  end

  wire       take   = rx_valid && !rec_valid;
  wire [7:0] byte_w = {hi_q, hx_val};
  wire       is_eol = (rx_data == 8'h0D) || (rx_data == 8'h0A);
  wire       in_dat = (idx >= BW'(4)) && (int'(idx) - 4 < int'(len_q));

  assign rec_len = len_q;
  assign rd_data = buf_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      sum       <= '0;
      hi_q      <= '0;
      len_q     <= '0;
      rec_addr  <= '0;
      rec_type  <= '0;
      rec_valid <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      tx_valid <= 1'b0;
      if (rec_ack) rec_valid <= 1'b0;
      if (take) begin
        case (st)
          S_IDLE: if (rx_data == 8'h3A) begin
            st  <= S_HI;
            idx <= '0;
            sum <= '0;
          end
          S_HI: if (hx_ok) begin
            hi_q <= hx_val;
            st   <= S_LO;
          end else begin
            tx_valid <= 1'b1; tx_data <= NAK_CHAR; st <= S_IDLE;
          end
          S_LO: if (!hx_ok) begin
            tx_valid <= 1'b1; tx_data <= NAK_CHAR; st <= S_IDLE;
          end else begin
            sum <= sum + byte_w;
            idx <= idx + 1'b1;
            st  <= S_HI;
            if (idx == '0) begin
              if (int'(byte_w) > MAX_LEN) begin
                tx_valid <= 1'b1; tx_data <= NAK_CHAR; st <= S_IDLE;
              end else len_q <= LW'(byte_w);
            end else if (idx == BW'(1)) rec_addr[15:8] <= byte_w;
            else if (idx == BW'(2))     rec_addr[7:0]  <= byte_w;
            else if (idx == BW'(3))     rec_type       <= byte_w;
            else if (int'(idx) == int'(len_q) + 4) st  <= S_EOL;
          end
          S_EOL: begin
            st       <= S_IDLE;
            tx_valid <= 1'b1;
            if (is_eol && sum == 8'h00) begin
              tx_data   <= ACK_CHAR;
              rec_valid <= 1'b1;
            end else tx_data <= NAK_CHAR;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (take && st == S_LO && hx_ok && in_dat)
      buf_q[AW'(idx - BW'(4))] <= byte_w;

endmodule

// File: rtl/ihex_rx_chk.sv
module ihex_rx_chk #(
  parameter int         MAX_LEN  = 32,
  parameter logic [7:0] ACK_CHAR = 8'h2E,
  parameter logic [7:0] NAK_CHAR = 8'h58
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tx_valid,
  input logic [7:0]                   tx_data,
  input logic                         rec_valid,
  input logic [7:0]                   rec_type,
  input logic [15:0]                  rec_addr,
  input logic [$clog2(MAX_LEN+1)-1:0] rec_len,
  input logic                         rec_ack
);
  a_r3_reply_code: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == ACK_CHAR || tx_data == NAK_CHAR));

  a_r3_ack_with_record: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> (tx_valid && tx_data == ACK_CHAR));

  a_r4_no_record_on_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_data == NAK_CHAR) |-> !$rose(rec_valid));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ack) |=> (rec_valid && $stable(rec_addr) && $stable(rec_type) && $stable(rec_len)));

  a_r9_no_reply_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ack) |=> !tx_valid);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ack) |=> !rec_valid);

  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (int'(rec_len) <= MAX_LEN));
endmodule

bind ihex_rx ihex_rx_chk #(.MAX_LEN(MAX_LEN), .ACK_CHAR(ACK_CHAR), .NAK_CHAR(NAK_CHAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
  .rec_valid(rec_valid), .rec_type(rec_type), .rec_addr(rec_addr),
  .rec_len(rec_len), .rec_ack(rec_ack)
);

// File: tb/ihex_rx_tb.sv
module ihex_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid, rec_valid;
  logic [7:0] tx_data, rec_type, rd_data;
  logic [15:0] rec_addr;
  logic [5:0] rec_len;
  logic [4:0] rd_idx = '0;
  logic       rec_ack = 1'b0;

  ihex_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .rec_valid(rec_valid),
    .rec_type(rec_type), .rec_addr(rec_addr), .rec_len(rec_len),
    .rd_idx(rd_idx), .rd_data(rd_data), .rec_ack(rec_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, tx_cnt = 0;
  logic [7:0] tx_last = 8'h00;
  bit done = 1'b0;

  always @(negedge clk) if (tx_valid) begin tx_cnt++; tx_last = tx_data; end

  typedef struct packed {
    logic [7:0]  len;
    logic [15:0] addr;
    logic [7:0]  typ;
    logic [1:0]  mode;   // 0 good, 1 bad checksum, 2 lower-case digits
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'd4,  16'h1234, 8'h00, 2'd0, 8'h2E},
    '{8'd0,  16'h0000, 8'h01, 2'd0, 8'h2E},
    '{8'd32, 16'hFFE0, 8'h00, 2'd0, 8'h2E},
    '{8'd3,  16'h0100, 8'h00, 2'd1, 8'h58},
    '{8'd5,  16'hABCD, 8'h00, 2'd2, 8'h2E},
    '{8'd2,  16'h0000, 8'h03, 2'd0, 8'h2E},
    '{8'd1,  16'h0000, 8'h00, 2'd1, 8'h58}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [15:0] a, input int i);
    return a[7:0] ^ 8'(i * 13 + 5);
  endfunction

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lc ? 8'h57 : 8'h37) + 8'(n);
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(negedge clk); rx_valid = 1'b1; rx_data = c;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lc);
    send_char(hexch(b[7:4], lc));
    send_char(hexch(b[3:0], lc));
  endtask

  task automatic send_rec(input logic [7:0] len, input logic [15:0] addr, input logic [7:0] typ,
                          input int mode, input logic [7:0] term);
    logic [7:0] s;
    bit lc;
    lc = (mode == 2);
    s = len + addr[15:8] + addr[7:0] + typ;
    send_char(8'h3A);
    send_byte(len, lc); send_byte(addr[15:8], lc); send_byte(addr[7:0], lc); send_byte(typ, lc);
    for (int i = 0; i < int'(len); i++) begin
      send_byte(dbyte(addr, i), lc);
      s = s + dbyte(addr, i);
    end
    s = -s;
    if (mode == 1) s = s + 8'd1;
    send_byte(s, lc);
    send_char(term);
    send_char(8'h0A);
  endtask

  task automatic do_ack();
    @(negedge clk); rec_ack = 1'b1;
    @(negedge clk); rec_ack = 1'b0;
  endtask

  task automatic check_rec(input logic [7:0] len, input logic [15:0] addr, input logic [7:0] typ, input string req);
    check(rec_valid === 1'b1, req, rec_valid, 1);
    check(rec_len === len[5:0], req, rec_len, len);
    check(rec_addr === addr, req, rec_addr, addr);
    check(rec_type === typ, req, rec_type, typ);
    for (int i = 0; i < int'(len); i++) begin
      @(negedge clk); rd_idx = 5'(i); #1;
      check(rd_data === dbyte(addr, i), req, rd_data, dbyte(addr, i));
    end
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0 && rec_valid === 1'b0, "R1 reset", {tx_valid, rec_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid === 1'b0 && rec_valid === 1'b0, "R1 after release", {tx_valid, rec_valid}, 0);

    for (int v = 0; v < 7; v++) begin
      c0 = tx_cnt;
      send_rec(VEC[v].len, VEC[v].addr, VEC[v].typ, int'(VEC[v].mode), 8'h0D);
      repeat (2) @(negedge clk);
      check(tx_cnt == c0 + 1 && tx_last == VEC[v].exp, "R3/R4/R6/R8/R10 reply", tx_last, VEC[v].exp);
      if (VEC[v].exp == 8'h2E) begin
        check_rec(VEC[v].len, VEC[v].addr, VEC[v].typ, "R3/R8/R10 record");
        do_ack();
        check(rec_valid === 1'b0, "R9 ack clears", rec_valid, 0);
      end else
        check(rec_valid === 1'b0, "R4 no record on bad sum", rec_valid, 0);
    end

    // R2: stray characters outside a record
    c0 = tx_cnt;
    send_char("Q"); send_char("7"); send_char(8'h0D); send_char("x");
    repeat (2) @(negedge clk);
    check(tx_cnt == c0 && rec_valid === 1'b0, "R2 stray chars ignored", tx_cnt - c0, 0);

    // R5: count 0x21 rejected right after the count pair
    c0 = tx_cnt;
    send_char(8'h3A); send_char("2"); send_char("1");
    @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h58, "R5 count over 32", tx_last, 8'h58);
    c0 = tx_cnt;
    send_rec(8'd1, 16'h4000, 8'h00, 0, 8'h0D);
    repeat (2) @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h2E, "R5 recovery", tx_last, 8'h2E);
    check_rec(8'd1, 16'h4000, 8'h00, "R5 recovery record");
    do_ack();

    // R7: non-hex character inside a record
    c0 = tx_cnt;
    send_char(8'h3A); send_char("0"); send_char("2"); send_char("G");
    @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h58, "R7 bad digit", tx_last, 8'h58);
    c0 = tx_cnt;
    send_char("5");
    send_rec(8'd2, 16'h5A5A, 8'h00, 0, 8'h0D);
    repeat (2) @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h2E, "R7 restart", tx_last, 8'h2E);
    check_rec(8'd2, 16'h5A5A, 8'h00, "R7 restart record");
    do_ack();

    // R11: bad terminator after checksum
    c0 = tx_cnt;
    send_rec(8'd1, 16'h0010, 8'h00, 0, "Z");
    repeat (2) @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h58 && rec_valid === 1'b0, "R11 bad terminator", tx_last, 8'h58);

    // R9: hold while unacknowledged, input ignored
    send_rec(8'd2, 16'h2222, 8'h00, 0, 8'h0D);
    repeat (2) @(negedge clk);
    c0 = tx_cnt;
    send_rec(8'd3, 16'h7777, 8'h05, 0, 8'h0D);
    repeat (2) @(negedge clk);
    check(tx_cnt == c0, "R9 no reply while held", tx_cnt - c0, 0);
    check_rec(8'd2, 16'h2222, 8'h00, "R9 held record");
    do_ack();
    check(rec_valid === 1'b0, "R9 ack clears", rec_valid, 0);
    c0 = tx_cnt;
    send_rec(8'd3, 16'h7777, 8'h05, 0, 8'h0D);
    repeat (2) @(negedge clk);
    check(tx_cnt == c0 + 1 && tx_last == 8'h2E, "R9 next record", tx_last, 8'h2E);
    check_rec(8'd3, 16'h7777, 8'h05, "R8/R9 next record");
    do_ack();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule